// File: doc/BRIEF.md
# Word shifter with carry and condition flags

This block shifts one data word left or right and works out the side flags that a processor's integer pipeline needs from such an operation. Four operations are supported: a logical left shift and a logical right shift by a register-held amount, an arithmetic right shift by a register-held amount, and an arithmetic right shift by a short immediate amount. Register amounts have one bit more than is needed to index the word. When that extra bit is set, the shift saturates and does not wrap. A logical shift then gives zero, and an arithmetic shift gives a word filled with the sign bit.

The two arithmetic shifts raise a carry-update enable. Their carry value goes to two flag outputs, the full carry and the 32-bit carry, which always carry the same value. When the record input is set, a condition-update enable comes with a four-bit nibble. The nibble classes the signed result as negative, positive or zero and passes the summary-overflow bit through. By default every output is registered on the rising edge and qualified by a valid strobe. A parameter can make the block purely combinational instead.

Top module: `word_shifter`

## Requirements
- R1: With op = 0 (logical left), the result is zero when the top bit of the register amount is set. Otherwise it is the source shifted left, zero-filled, by the amount's low bits.
- R2: With op = 1 (logical right), the result is zero when the top bit of the register amount is set. Otherwise it is the source shifted right, zero-filled, by the amount's low bits.
- R3: With op = 2 (arithmetic right, register amount) and the amount's top bit set, every result bit equals the source sign bit. The carry is 1 only when the source is negative and one of its bits below the sign is 1.
- R4: With op = 2 and the amount's top bit clear, the result is the source shifted right with sign fill by the low bits. The carry is 1 only when the source is negative and a 1 bit was shifted out. An amount of zero returns the source unchanged with carry 0.
- R5: With op = 3 (arithmetic right, immediate amount), the source shifts right with sign fill by the immediate, and the register amount is ignored. The carry rule is the one in R4. An immediate of zero returns the source with carry 0.
- R6: The carry-update enable is high exactly for valid operations with op = 2 or 3. The carry and the 32-bit carry outputs are always equal, and both are 0 while the enable is low.
- R7: The condition-update enable equals the record input of a valid operation. The nibble is {negative, positive, zero, summary-overflow input}, judged on the signed result. Exactly one of its upper three bits is set.
- R8: In registered mode, reset clears the valid output and both update enables. An operation presented with its valid strobe appears on the outputs after the next rising edge, and a cycle without the strobe leaves the valid output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registered mode |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 0 shl, 1 shr logical, 2 sar by register, 3 sar by immediate |
| src | input | WIDTH | Operand to shift |
| amt_reg | input | log2(WIDTH)+1 | Register shift amount; top bit means saturate |
| amt_imm | input | log2(WIDTH) | Immediate shift amount |
| rec | input | 1 | Request condition-field update |
| so_in | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Outputs hold a completed operation |
| result | output | WIDTH | Shifted word |
| ca_we | output | 1 | Carry-update enable |
| ca | output | 1 | Carry value |
| ca32 | output | 1 | 32-bit carry value, equal to ca |
| cr_we | output | 1 | Condition-field update enable |
| cr | output | 4 | {negative, positive, zero, summary-overflow} |

## Verification
The bench builds the block at an 8-bit word and applies every source value with every register amount from 0 to 15, under all four operations. This reaches the in-range amounts, the saturating amounts and the boundary between them. Negative sources whose shifted-out bits are all zero are part of the sweep, so a carry taken from the sign alone is told apart from the correct rule. The source 0x80 with a saturating arithmetic shift separates the "low bits below the sign" carry rule from a simple "anything shifted out" rule. The record and summary-overflow inputs are toggled from the operand bits, so the nibble is checked for negative, positive and zero results both with and without an update.

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int WIDTH      = 32,
  parameter bit REGISTERED = 1'b1,
  localparam int AW        = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] src,
  input  logic [AW:0]      amt_reg,
  input  logic [AW-1:0]    amt_imm,
  input  logic             rec,
  input  logic             so_in,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             ca_we,
  output logic             ca,
  output logic             ca32,
  output logic             cr_we,
  output logic [3:0]       cr
);

  logic [AW-1:0]    n;
  logic             big;
  logic [WIDTH-1:0] res, out_mask;
  logic             sign, carry;

  assign n        = (op == 2'd3) ? amt_imm : amt_reg[AW-1:0];
  assign big      = (op != 2'd3) & amt_reg[AW];
  assign sign     = src[WIDTH-1];
  assign out_mask = ~({WIDTH{1'b1}} << n);

  always_comb begin
    case (op)
      2'd0:    res = big ? '0 : (src << n);
      2'd1:    res = big ? '0 : (src >> n);
      default: res = big ? {WIDTH{sign}} : WIDTH'($signed(src) >>> n);
    endcase
  end

  assign carry = sign & (big ? |src[WIDTH-2:0] : |(src & out_mask));

  logic             c_ca_we, c_ca, c_cr_we;
  logic [3:0]       c_cr;

  assign c_ca_we = in_valid & op[1];
  assign c_ca    = c_ca_we & carry;
  assign c_cr_we = in_valid & rec;
  assign c_cr    = {res[WIDTH-1], ~res[WIDTH-1] & |res, ~|res, so_in};

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          result    <= '0;
          ca_we     <= 1'b0;
          ca        <= 1'b0;
          cr_we     <= 1'b0;
          cr        <= '0;
        end else begin
          out_valid <= in_valid;
          result    <= res;
          ca_we     <= c_ca_we;
          ca        <= c_ca;
          cr_we     <= c_cr_we;
          cr        <= c_cr;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = res;
      assign ca_we     = c_ca_we;
      assign ca        = c_ca;
      assign cr_we     = c_cr_we;
      assign cr        = c_cr;
    end
  endgenerate

  assign ca32 = ca;

endmodule

// File: rtl/word_shifter_chk.sv
module word_shifter_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             out_valid,
  input logic [WIDTH-1:0] result,
  input logic             ca_we,
  input logic             ca,
  input logic             ca32,
  input logic             cr_we,
  input logic [3:0]       cr
);

  AST_CARRY_PAIR: assert property (@(posedge clk) disable iff (rst) ca == ca32); // R6
  AST_CARRY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) ca |-> ca_we); // R6
  AST_CARRY_NEG_RESULT: assert property (@(posedge clk) disable iff (rst) ca |-> result[WIDTH-1]); // R4
  AST_IDLE_NO_UPDATE: assert property (@(posedge clk) disable iff (rst) !out_valid |-> (!ca_we && !cr_we)); // R8
  AST_CR_ONE_CLASS: assert property (@(posedge clk) disable iff (rst) cr_we |-> ($countones(cr[3:1]) == 1)); // R7
  AST_CR_ZERO: assert property (@(posedge clk) disable iff (rst) cr_we |-> (cr[1] == (result == '0))); // R7
  AST_CR_SIGN: assert property (@(posedge clk) disable iff (rst) cr_we |-> (cr[3] == result[WIDTH-1])); // R7

endmodule

bind word_shifter word_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .result(result),
  .ca_we(ca_we), .ca(ca), .ca32(ca32), .cr_we(cr_we), .cr(cr)
);

// File: tb/sim_word_shifter.sv
`timescale 1ns/1ps
module sim_word_shifter;
  localparam int W  = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, in_valid, rec, so_in;
  logic [1:0]    op;
  logic [W-1:0]  src;
  logic [AW:0]   amt_reg;
  logic [AW-1:0] amt_imm;
  logic          out_valid, ca_we, ca, ca32, cr_we;
  logic [W-1:0]  result;
  logic [3:0]    cr;

  word_shifter #(.WIDTH(W), .REGISTERED(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .src(src),
    .amt_reg(amt_reg), .amt_imm(amt_imm), .rec(rec), .so_in(so_in),
    .out_valid(out_valid), .result(result), .ca_we(ca_we), .ca(ca),
    .ca32(ca32), .cr_we(cr_we), .cr(cr)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d src=%h amt=%0d imm=%0d actual=%h expected=%h",
               tag, op, src, amt_reg, amt_imm, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; rec = 1'b1; so_in = 1'b1;
    op = 2'd2; src = 8'h81; amt_reg = '0; amt_imm = '0;
    @(negedge clk); @(negedge clk);
    chk("R8 reset", {29'd0, out_valid, ca_we, cr_we}, 32'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R8 no strobe", {29'd0, out_valid, ca_we, cr_we}, 32'd0);

    for (int o = 0; o < 4; o++) begin
      for (int s = 0; s < 256; s++) begin
        for (int a = 0; a < 16; a++) begin
          int n, sv, r, c;
          bit big, cawe, lt, eq, gt, rc, so;
          string tag;
          n   = (o == 3) ? (a & 7) : a;
          big = (o != 3) && (n >= 8);
          sv  = (s >= 128) ? s - 256 : s;
          rc  = s[0] ^ a[0];
          so  = s[1] ^ a[1];
          c   = 0;
          case (o)
            0: begin r = big ? 0 : (s << n) & 255; tag = "R1"; end
            1: begin r = big ? 0 : s >> n; tag = "R2"; end
            default: begin
              r = big ? (sv < 0 ? 255 : 0) : ((sv >>> n) & 255);
              c = (sv < 0 && (big ? ((s & 127) != 0) : ((s % (1 << n)) != 0))) ? 1 : 0;
              tag = (o == 3) ? "R5/R6" : (big ? "R3/R6" : "R4/R6");
            end
          endcase
          cawe = (o >= 2);
          lt = (r >= 128); eq = (r == 0); gt = !lt && !eq;
          op = 2'(o); src = 8'(s); amt_reg = 4'(a); amt_imm = 3'(a ^ 5);
          if (o == 3) amt_imm = 3'(a);
          if (o == 3) amt_reg = 4'(15 - a);
          rec = rc; so_in = so; in_valid = 1'b1;
          @(negedge clk);
          chk({tag, "/R7/R8"},
              {16'd0, out_valid, result, ca_we, ca, ca32, cr_we, cr},
              {16'd0, 1'b1, 8'(r), cawe, cawe & (c != 0), cawe & (c != 0),
               rc, (rc ? {lt, gt, eq, so} : {lt, gt, eq, so})});
        end
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 strobe drop", {29'd0, out_valid, ca_we, cr_we}, 32'd0);
    finish_run();
  end

endmodule